// File: doc/BRIEF.md
# Bit-Slot Frame Transmitter

This block sends one node's frame words onto a serial line that several nodes share one bit at a time. A round-robin synchronizer elsewhere produces a one-cycle strobe when this node's slot begins. On each accepted strobe the block takes the next bit of the current word and drives it onto the line for one bit time. The bit is Manchester coded, so the line changes level in the middle of every bit. Outside that window the output enable is low and other nodes own the line.

Local logic hands in words through a valid/ready write port into a small queue. A word is taken from the queue only at a word boundary, and its bits go out most-significant first, one per owned slot. If the queue is empty at a boundary, a reserved idle word goes out in its place, so receivers always see transitions in this node's slots.

Top module: `bitslot_tx`

## Requirements
- R1: While reset is high and after it is released, `line_oe` and `line_o` are 0 and `wr_ready` is 1 until a slot strobe is accepted or the queue fills.
- R2: A `slot_go` pulse seen while no bit is being sent starts a bit: `line_oe` is high for exactly 2*HALF_CLKS cycles, starting the cycle after the strobe, and it is low at all other times.
- R3: Bit coding: a 1 is sent as `line_o` low for the first HALF_CLKS cycles of the window and high for the second HALF_CLKS; a 0 is sent as high then low.
- R4: Each word is sent as WORD_W consecutive owned-slot bits, bit WORD_W-1 first, then down to bit 0.
- R5: A word is taken from the queue only at the first bit of a word. A word written while another word is part sent does not change the remaining bits of that word.
- R6: If the queue is empty when a word begins, the word IDLE_WORD (default 16'h7E7E) is sent in full instead.
- R7: Queued words are sent in write order. The queue holds FIFO_DEPTH+1 words. `wr_ready` is low when it is full, and a write offered with `wr_ready` low is dropped.
- R8: A `slot_go` pulse that arrives while a bit window is in progress is ignored and takes no bit.
- R9: `line_o` is 0 whenever `line_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request into the word queue |
| wr_data | input | WORD_W | Word to queue |
| wr_ready | output | 1 | Queue can accept a word |
| slot_go | input | 1 | One-cycle strobe at the start of this node's slot |
| line_o | output | 1 | Manchester-coded line level |
| line_oe | output | 1 | Line drive enable, high only during an owned bit window |

## Verification
The assertions assume that the synchronizer issues `slot_go` as a single-cycle pulse, and that a strobe during a window is the only case where two starts could overlap. The bench therefore spaces slots by three bit times, the way three nodes would share the line, and it pulses a longer strobe only in the case that checks R8. Queue writes are placed between slots and at known word positions, so the expected order of idle and data words follows from the requirements alone.

// File: rtl/bitslot_tx_pkg.sv
package bitslot_tx_pkg;
  typedef enum logic [1:0] {
    ENC_IDLE   = 2'd0,
    ENC_FIRST  = 2'd1,
    ENC_SECOND = 2'd2
  } enc_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push, fetch;

  assign wr_ready = (count != CW'(DEPTH));
  assign push     = wr_valid && wr_ready;
  assign fetch    = (!head_valid || pop) && (count != '0);

  // storage: write port and registered read, block RAM friendly
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
    if (fetch) head_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      head_valid <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (fetch) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(fetch);
      if (fetch) head_valid <= 1'b1;
      else if (pop) head_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_seq.sv
module bit_seq #(
  parameter int         W         = 16,
  parameter logic [W-1:0] IDLE_WORD = 16'h7E7E
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         head_valid,
  input  logic [W-1:0] head_data,
  output logic         pop,
  output logic         cur_bit
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  shreg;
  logic [IW-1:0] idx;
  logic          at_boundary;
  logic [W-1:0]  next_word;

  assign next_word = head_valid ? head_data : IDLE_WORD;
  assign cur_bit   = at_boundary ? next_word[W-1] : shreg[W-1];
  assign pop       = take && at_boundary && head_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      idx         <= '0;
      at_boundary <= 1'b1;
    end else if (take) begin
      if (at_boundary) begin
        shreg       <= next_word << 1;
        idx         <= IW'(1);
        at_boundary <= 1'b0;
      end else if (idx == IW'(W - 1)) begin
        idx         <= '0;
        at_boundary <= 1'b1;
      end else begin
        shreg <= shreg << 1;
        idx   <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/manch_enc.sv
module manch_enc
  import bitslot_tx_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_go,
  input  logic bit_in,
  output logic take,
  output logic line_o,
  output logic line_oe
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  enc_state_e    state;
  logic [CW-1:0] cnt;
  logic          held;

  assign take = slot_go && (state == ENC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENC_IDLE;
      cnt     <= '0;
      held    <= 1'b0;
      line_o  <= 1'b0;
      line_oe <= 1'b0;
    end else begin
      case (state)
        ENC_IDLE: begin
          if (take) begin
            state   <= ENC_FIRST;
            cnt     <= '0;
            held    <= bit_in;
            line_o  <= ~bit_in;
            line_oe <= 1'b1;
          end
        end
        ENC_FIRST: begin
          if (cnt == CW'(HALF - 1)) begin
            state  <= ENC_SECOND;
            cnt    <= '0;
            line_o <= held;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENC_SECOND: begin
          if (cnt == CW'(HALF - 1)) begin
            state   <= ENC_IDLE;
            cnt     <= '0;
            line_o  <= 1'b0;
            line_oe <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state   <= ENC_IDLE;
          line_o  <= 1'b0;
          line_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitslot_tx.sv
module bitslot_tx #(
  parameter int              WORD_W     = 16,
  parameter int              FIFO_DEPTH = 4,
  parameter int              HALF_CLKS  = 4,
  parameter logic [WORD_W-1:0] IDLE_WORD  = 16'h7E7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              slot_go,
  output logic              line_o,
  output logic              line_oe
);
  logic              pop, head_valid, take, cur_bit;
  logic [WORD_W-1:0] head_data;

  txq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .pop(pop), .head_valid(head_valid), .head_data(head_data)
  );

  bit_seq #(.W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_seq (
    .clk(clk), .rst(rst), .take(take),
    .head_valid(head_valid), .head_data(head_data),
    .pop(pop), .cur_bit(cur_bit)
  );

  manch_enc #(.HALF(HALF_CLKS)) u_enc (
    .clk(clk), .rst(rst), .slot_go(slot_go), .bit_in(cur_bit),
    .take(take), .line_o(line_o), .line_oe(line_oe)
  );
endmodule

// File: rtl/bitslot_tx_chk.sv
module bitslot_tx_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic slot_go,
  input logic line_o,
  input logic line_oe
);
  localparam int RW = $clog2(2 * HALF) + 2;

  logic [RW-1:0] run;
  logic          first_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= '0;
      first_val <= 1'b0;
    end else begin
      run <= line_oe ? run + 1'b1 : '0;
      if (line_oe && run == '0) first_val <= line_o;
    end
  end

  // R2
  oe_bound_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> run < RW'(2 * HALF));

  // R2
  oe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> run == RW'(2 * HALF));

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe) |-> $past(slot_go));

  // R3
  mid_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (line_oe && run == RW'(HALF)) |-> line_o != first_val);

  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> !line_o);
endmodule

bind bitslot_tx bitslot_tx_chk #(.HALF(HALF_CLKS)) u_chk (
  .clk(clk), .rst(rst), .slot_go(slot_go), .line_o(line_o), .line_oe(line_oe)
);

// File: tb/bitslot_tx_bench.sv
module bitslot_tx_bench;
  localparam int W    = 16;
  localparam int HALF = 4;
  localparam logic [W-1:0] IDLE = 16'h7E7E;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         wr_ready;
  logic         slot_go = 1'b0;
  logic         line_o, line_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit exp_q[$];

  always #4 clk = ~clk;

  bitslot_tx u_bitslot_tx (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .slot_go(slot_go), .line_o(line_o), .line_oe(line_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic queue_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  // driver: offers a word, queues it as expected only if accepted
  task automatic push_word(input logic [W-1:0] w, output bit acc);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    acc      = wr_ready;
    if (acc) queue_word(w);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // one owned slot, then two other-node slots of silence
  task automatic do_slot(input int hold);
    @(negedge clk);
    slot_go = 1'b1;
    repeat (hold) @(negedge clk);
    slot_go = 1'b0;
    repeat (6 * HALF) @(negedge clk);
    check(line_oe == 1'b0 && line_o == 1'b0, "R9/R2 quiet", {line_oe, line_o}, 0);
  endtask

  task automatic slots(input int n, input int hold);
    for (int i = 0; i < n; i++) do_slot(hold);
  endtask

  // monitor: decodes each bit window and compares with the expected queue
  initial begin
    forever begin
      bit v1, v2, e;
      @(posedge line_oe);
      @(negedge clk);
      v1 = line_o;
      repeat (HALF) @(negedge clk);
      check(line_oe == 1'b1, "R2 window", line_oe, 1);
      v2 = line_o;
      check(v1 != v2, "R3 mid-bit transition", {v1, v2}, {~v2, v2});
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected bit", v2, 0);
      end else begin
        e = exp_q.pop_front();
        check(v2 == e, "R4/R5/R6/R7 bit value", v2, e);
      end
      repeat (HALF) @(negedge clk);
      check(line_oe == 1'b0, "R2 window end", line_oe, 0);
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    bit acc;
    int n_acc;
    repeat (3) @(negedge clk);
    check(line_oe == 1'b0 && line_o == 1'b0, "R1 reset outputs", {line_oe, line_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(line_oe == 1'b0 && wr_ready == 1'b1, "R1 after reset", {line_oe, wr_ready}, 1);

    // R6: empty queue gives idle word
    queue_word(IDLE);
    slots(W, 1);

    // R4 / R7: two words, MSB first, in order
    push_word(16'hA5C3, acc);
    push_word(16'h8001, acc);
    slots(2 * W, 1);

    // R5: word written mid-idle waits for the boundary
    queue_word(IDLE);
    slots(5, 1);
    push_word(16'h1234, acc);
    slots(W - 5, 1);
    slots(W, 1);

    // R8: strobe held across a window takes a single bit
    push_word(16'hF00F, acc);
    slots(W, 3);

    // R7: fill the queue, extra write dropped
    n_acc = 0;
    for (int i = 0; i < 6; i++) begin
      push_word(16'h3C00 + 16'(i * 17), acc);
      if (acc) n_acc++;
    end
    check(n_acc == 5, "R7 capacity", n_acc, 5);
    check(wr_ready == 1'b0, "R7 ready low when full", wr_ready, 0);
    slots(5 * W, 1);

    // R6: drained queue falls back to idle
    queue_word(IDLE);
    slots(W, 1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all bits sent", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule